// File: doc/BRIEF.md
# Multi-line DMA interrupt and register decoder

This block is the global register front end of a multi-channel DMA controller. It decodes a 4 KB register window. The window holds a fixed revision word, four interrupt status registers, four interrupt enable registers and a run of per-channel register slots. The channel slots start at 0x80 and repeat every 0x60 bytes. For a channel access the block passes the channel number and the local offset to the channel register banks, which sit outside this block, and returns the word those banks supply.

Each of the four interrupt lines has its own status/enable pair. A channel event pulse on channel c sets bit c in every status register whose enable has bit c set. Software clears status bits by writing ones to them. A line is high whenever its status ANDed with its enable is non-zero. Reads answer one cycle after the request. Rejected accesses raise a one-cycle error flag beside the response.

Top module: `dmairq_front`

## Requirements
- R1: A read of offset 0x00 returns 0x00000040. Writes to 0x00 change nothing.
- R2: Offsets 0x18, 0x1C, 0x20 and 0x24 hold the enable registers of lines 0 to 3. A word write replaces the whole register, and a read returns it.
- R3: Offsets 0x08, 0x0C, 0x10 and 0x14 hold the status registers of lines 0 to 3. A write clears each bit written as 1 and leaves the other bits unchanged.
- R4: When event bit c pulses, bit c of status k is set exactly when bit c of enable k is set at that edge. Status bits are set by nothing else.
- R5: If a status bit is cleared by a write in the same cycle as an event that sets it, the bit ends up set.
- R6: Output irq[k] is high exactly when status k AND enable k is non-zero. It falls after the clear that empties that product, or after the enable is removed.
- R7: An access in 0x80..0xFFF with channel number (offset-0x80)/0x60 below NUM_CH asserts ch_req in the same cycle. The same cycle carries ch_idx equal to that quotient, ch_off equal to the remainder, and ch_we equal to the write flag. A channel read returns ch_rdata unchanged.
- R8: bus_size encodes 0 = byte, 1 = half-word, 2 = word and 3 = reserved. Byte and reserved accesses change no register and raise no ch_req. Such a read returns zero, and either kind of access pulses rsp_err.
- R9: A read of an offset with no register, including a channel number of NUM_CH or more, returns zero with rsp_err high and raises no ch_req.
- R10: In a half-word access to a global register, bus_addr[1] selects the upper (1) or lower (0) 16 bits. A write uses bus_wdata[15:0] and touches only that half. A read returns that half in bits 15:0, with zeros above.
- R11: After reset every status and enable register is zero and every irq line is low.
- R12: rsp_valid pulses in the cycle after each accepted read request, and only then. rsp_data and rsp_err describe that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data |
| chan_event | input | NUM_CH | One-cycle event pulse per channel |
| ch_rdata | input | 32 | Read word from the addressed channel bank |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| rsp_err | output | 1 | Rejected or unmapped access |
| irq | output | NUM_LINES | Interrupt lines |
| ch_req | output | 1 | Channel slot access this cycle |
| ch_we | output | 1 | Channel access is a write |
| ch_idx | output | 6 | Channel number |
| ch_off | output | 7 | Byte offset inside the channel slot |

## Verification
The bench aims a clear and a setting event at the same status bit in the same cycle. A design that gave the clear priority would lose the event, and the interrupt line would fall. It probes both ends of each channel slot and the first address past the last configured channel. A wrong stride or an off-by-one bound there would send the access to the wrong bank or accept a channel that does not exist. Half-word writes to the upper enable half, byte accesses and removed enables are covered too. Each would show up as a corrupted neighbour half, a register changed by a rejected access, or an interrupt line that stays high with nothing enabled.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_REV,
        RG_STAT,
        RG_EN,
        RG_CHAN
    } region_e;

    localparam logic [31:0] REV_VALUE  = 32'h0000_0040;
    localparam logic [11:0] STAT_BASE  = 12'h008;
    localparam logic [11:0] EN_BASE    = 12'h018;
    localparam logic [11:0] CH_BASE    = 12'h080;
    localparam logic [11:0] CH_STRIDE  = 12'd96;
    localparam int          CH_SLOTS   = (4096 - 128) / 96;
    localparam int          CH_IDX_W   = $clog2(CH_SLOTS + 1);

endpackage

// File: rtl/dmairq_decode.sv
module dmairq_decode
    import dmairq_pkg::*;
#(
    parameter int NUM_CH    = 32,
    parameter int NUM_LINES = 4,
    parameter int LINE_W    = 2
) (
    input  logic [11:0]         addr,
    input  logic [1:0]          size,
    output region_e             region,
    output logic [LINE_W-1:0]   line,
    output logic                size_ok,
    output logic [CH_IDX_W-1:0] ch_idx,
    output logic [6:0]          ch_off
);

    localparam logic [11:0] STAT_END = STAT_BASE + 12'(4 * NUM_LINES);
    localparam logic [11:0] EN_END   = EN_BASE + 12'(4 * NUM_LINES);

    logic [11:0] aw;
    logic [11:0] rel;
    logic [11:0] quot;
    logic [11:0] rem;

    assign aw      = {addr[11:2], 2'b00};
    assign rel     = addr - CH_BASE;
    assign quot    = rel / CH_STRIDE;
    assign rem     = rel - quot * CH_STRIDE;
    assign ch_idx  = quot[CH_IDX_W-1:0];
    assign ch_off  = rem[6:0];
    assign size_ok = (size == SZ_HALF) || (size == SZ_WORD);

    always_comb begin
        region = RG_NONE;
        line   = '0;
        if (aw == 12'h000) begin
            region = RG_REV;
        end else if (aw >= STAT_BASE && aw < STAT_END) begin
            region = RG_STAT;
            line   = LINE_W'((aw - STAT_BASE) >> 2);
        end else if (aw >= EN_BASE && aw < EN_END) begin
            region = RG_EN;
            line   = LINE_W'((aw - EN_BASE) >> 2);
        end else if (addr >= CH_BASE && quot < 12'(NUM_CH)) begin
            region = RG_CHAN;
        end
    end

endmodule

// File: rtl/dmairq_line.sv
module dmairq_line #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev,
    input  logic              clr_we,
    input  logic              en_we,
    input  logic [NUM_CH-1:0] wmask,
    input  logic [NUM_CH-1:0] wval,
    output logic [NUM_CH-1:0] stat,
    output logic [NUM_CH-1:0] en,
    output logic              irq_o
);

    logic [NUM_CH-1:0] set_bits;
    logic [NUM_CH-1:0] clr_bits;

    assign set_bits = ev & en;
    assign clr_bits = clr_we ? wval : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
            en   <= '0;
        end else begin
            stat <= (stat & ~clr_bits) | set_bits;
            if (en_we) begin
                en <= (en & ~wmask) | (wval & wmask);
            end
        end
    end

    assign irq_o = |(stat & en);

    assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev & en)) |=> ((stat & $past(ev & en)) == $past(ev & en)));

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((ev & en) == '0)) |=> ((stat & $past(wval)) == '0));

    assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & en) == '0) |=> ((stat & ~$past(stat)) == '0));

endmodule

// File: rtl/dmairq_front.sv
module dmairq_front
    import dmairq_pkg::*;
#(
    parameter int NUM_CH    = 32,
    parameter int NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [11:0]          bus_addr,
    input  logic [1:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    input  logic [NUM_CH-1:0]    chan_event,
    input  logic [31:0]          ch_rdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_data,
    output logic                 rsp_err,
    output logic [NUM_LINES-1:0] irq,
    output logic                 ch_req,
    output logic                 ch_we,
    output logic [CH_IDX_W-1:0]  ch_idx,
    output logic [6:0]           ch_off
);

    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    region_e           region;
    logic [LINE_W-1:0] line;
    logic              size_ok;
    logic              acc_ok;
    logic [31:0]       wmask;
    logic [31:0]       wval;
    logic [31:0]       stat_w [NUM_LINES];
    logic [31:0]       en_w   [NUM_LINES];
    logic [31:0]       rd_word;
    logic              rd_hit;

    dmairq_decode #(
        .NUM_CH    (NUM_CH),
        .NUM_LINES (NUM_LINES),
        .LINE_W    (LINE_W)
    ) u_decode (
        .addr    (bus_addr),
        .size    (bus_size),
        .region  (region),
        .line    (line),
        .size_ok (size_ok),
        .ch_idx  (ch_idx),
        .ch_off  (ch_off)
    );

    assign acc_ok = bus_valid && size_ok;
    assign ch_req = acc_ok && (region == RG_CHAN);
    assign ch_we  = ch_req && bus_write;

    always_comb begin
        if (bus_size == SZ_HALF) begin
            wmask = bus_addr[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
            wval  = {bus_wdata[15:0], bus_wdata[15:0]} & wmask;
        end else begin
            wmask = 32'hFFFF_FFFF;
            wval  = bus_wdata;
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [NUM_CH-1:0] s_l;
        logic [NUM_CH-1:0] e_l;

        dmairq_line #(.NUM_CH(NUM_CH)) u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev     (chan_event),
            .clr_we (acc_ok && bus_write && region == RG_STAT && line == LINE_W'(g)),
            .en_we  (acc_ok && bus_write && region == RG_EN && line == LINE_W'(g)),
            .wmask  (wmask[NUM_CH-1:0]),
            .wval   (wval[NUM_CH-1:0]),
            .stat   (s_l),
            .en     (e_l),
            .irq_o  (irq[g])
        );

        assign stat_w[g] = 32'(s_l);
        assign en_w[g]   = 32'(e_l);
    end

    always_comb begin
        rd_word = '0;
        rd_hit  = 1'b0;
        unique case (region)
            RG_REV:  begin rd_word = REV_VALUE;    rd_hit = 1'b1; end
            RG_STAT: begin rd_word = stat_w[line]; rd_hit = 1'b1; end
            RG_EN:   begin rd_word = en_w[line];   rd_hit = 1'b1; end
            RG_CHAN: begin rd_word = ch_rdata;     rd_hit = 1'b1; end
            RG_NONE: begin rd_word = '0;           rd_hit = 1'b0; end
        endcase
        if (region != RG_CHAN && bus_size == SZ_HALF) begin
            rd_word = bus_addr[1] ? {16'h0000, rd_word[31:16]} : {16'h0000, rd_word[15:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= bus_valid && !bus_write;
            rsp_data  <= (bus_valid && !bus_write && size_ok && rd_hit) ? rd_word : '0;
            rsp_err   <= bus_valid && (!size_ok || (!bus_write && !rd_hit));
        end
    end

    assert_chan_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ch_req |-> (ch_idx < CH_IDX_W'(NUM_CH)));

    assert_chan_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ch_req |-> (ch_off < 7'd96));

    assert_byte_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_size == SZ_BYTE)) |-> !ch_req);

    assert_rsp_after_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_valid && !bus_write));

    assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_data == '0));

endmodule

// File: tb/test_dmairq_front.sv
`timescale 1ns/1ps
module test_dmairq_front;
    import dmairq_pkg::*;

    localparam int NCH = 32;
    localparam int NL  = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_valid, bus_write;
    logic [11:0]       bus_addr;
    logic [1:0]        bus_size;
    logic [31:0]       bus_wdata;
    logic [NCH-1:0]    chan_event;
    logic [31:0]       ch_rdata;
    logic              rsp_valid, rsp_err;
    logic [31:0]       rsp_data;
    logic [NL-1:0]     irq;
    logic              ch_req, ch_we;
    logic [5:0]        ch_idx;
    logic [6:0]        ch_off;

    always #2 clk = ~clk;

    dmairq_front #(.NUM_CH(NCH), .NUM_LINES(NL)) i_dmairq_front (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .chan_event(chan_event), .ch_rdata(ch_rdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .irq(irq), .ch_req(ch_req),
        .ch_we(ch_we), .ch_idx(ch_idx), .ch_off(ch_off)
    );

    assign ch_rdata = {16'hC0DE, 2'b00, ch_idx, 1'b0, ch_off};

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] m_stat [NL];
    logic [31:0] m_en   [NL];
    logic        e_rv = 1'b0;
    logic        e_re = 1'b0;
    logic [31:0] e_rd = '0;
    string       e_tag = "R11 reset";

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic step(input bit v, input bit we, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] ev, input string tag);
        logic [NL-1:0] ei;
        logic [11:0]   aw;
        logic [31:0]   mk, wv, val, clr, ns;
        bit            sz_ok, hit, exp_req;
        int            kind, kk, ci, co;
        @(negedge clk);
        chk(rsp_valid === e_rv, {e_tag, " R12 rsp_valid"}, 32'(rsp_valid), 32'(e_rv));
        if (e_rv) chk(rsp_data === e_rd, {e_tag, " rsp_data"}, rsp_data, e_rd);
        chk(rsp_err === e_re, {e_tag, " rsp_err"}, 32'(rsp_err), 32'(e_re));
        for (int k = 0; k < NL; k++) ei[k] = |(m_stat[k] & m_en[k]);
        chk(irq === ei, {e_tag, " R6 irq"}, 32'(irq), 32'(ei));

        bus_valid = v; bus_write = we; bus_addr = a; bus_size = sz;
        bus_wdata = wd; chan_event = ev;
        #1;
        sz_ok = (sz == 2'd1) || (sz == 2'd2);
        aw = {a[11:2], 2'b00};
        kind = 0; kk = 0; ci = 0; co = 0;
        if (aw == 12'h000) kind = 1;
        else if (aw >= 12'h008 && aw <= 12'h014) begin kind = 2; kk = (int'(aw) - 8) / 4; end
        else if (aw >= 12'h018 && aw <= 12'h024) begin kind = 3; kk = (int'(aw) - 24) / 4; end
        else if (a >= 12'h080) begin
            ci = (int'(a) - 128) / 96;
            co = (int'(a) - 128) % 96;
            if (ci < NCH) kind = 4;
        end
        exp_req = v && sz_ok && (kind == 4);
        chk(ch_req === exp_req, {tag, " R7 R9 ch_req"}, 32'(ch_req), 32'(exp_req));
        if (exp_req) begin
            chk(ch_idx === 6'(ci), {tag, " R7 ch_idx"}, 32'(ch_idx), 32'(ci));
            chk(ch_off === 7'(co), {tag, " R7 ch_off"}, 32'(ch_off), 32'(co));
            chk(ch_we === we, {tag, " R7 ch_we"}, 32'(ch_we), 32'(we));
        end

        if (sz == 2'd1) begin
            mk = a[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
            wv = {wd[15:0], wd[15:0]} & mk;
        end else begin
            mk = 32'hFFFF_FFFF;
            wv = wd;
        end

        hit = 1'b1;
        case (kind)
            1: val = 32'h40;
            2: val = m_stat[kk];
            3: val = m_en[kk];
            4: val = {16'hC0DE, 2'b00, 6'(ci), 1'b0, 7'(co)};
            default: begin val = 0; hit = 1'b0; end
        endcase
        if (kind != 4 && sz == 2'd1) val = a[1] ? (val >> 16) : (val & 32'h0000_FFFF);
        e_rv  = v && !we;
        e_rd  = (v && !we && sz_ok && hit) ? val : 32'h0;
        e_re  = v && (!sz_ok || (!we && !hit));
        e_tag = tag;

        for (int k = 0; k < NL; k++) begin
            clr = (v && we && sz_ok && kind == 2 && kk == k) ? wv : 32'h0;
            ns  = (m_stat[k] & ~clr) | (ev & m_en[k]);
            if (v && we && sz_ok && kind == 3 && kk == k) m_en[k] = (m_en[k] & ~mk) | wv;
            m_stat[k] = ns;
        end
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] sz, input string tag);
        step(1'b1, 1'b0, a, sz, 32'h0, 32'h0, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d,
                      input logic [31:0] ev, input string tag);
        step(1'b1, 1'b1, a, sz, d, ev, tag);
    endtask

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        for (int k = 0; k < NL; k++) begin m_stat[k] = 0; m_en[k] = 0; end
        rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
        bus_size = 2'd2; bus_wdata = '0; chan_event = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(12'h018, 2'd2, "R11 reset enable");
        rd(12'h008, 2'd2, "R11 reset status");
        // R1 revision
        rd(12'h000, 2'd2, "R1 revision");
        wr(12'h000, 2'd2, 32'hFFFF_FFFF, 0, "R1 write ignored");
        rd(12'h000, 2'd2, "R1 revision after write");
        // R2 enables
        wr(12'h018, 2'd2, 32'h0000_00FF, 0, "R2 en0");
        wr(12'h01C, 2'd2, 32'hFF00_0000, 0, "R2 en1");
        wr(12'h020, 2'd2, 32'h0000_0001, 0, "R2 en2");
        wr(12'h024, 2'd2, 32'h0000_0000, 0, "R2 en3");
        for (int k = 0; k < 4; k++) rd(12'(24 + 4 * k), 2'd2, "R2 enable readback");
        // R4 R6 events
        step(1'b0, 1'b0, 0, 2'd2, 0, 32'h8000_0081, "R4 event");
        for (int k = 0; k < 4; k++) rd(12'(8 + 4 * k), 2'd2, "R4 status readback");
        // R3 partial clear
        wr(12'h008, 2'd2, 32'h0000_0001, 0, "R3 clear bit0");
        rd(12'h008, 2'd2, "R3 status after clear");
        // R5 clear and set together
        wr(12'h008, 2'd2, 32'h0000_0080, 32'h0000_0080, "R5 set beats clear");
        rd(12'h008, 2'd2, "R5 status kept");
        // R6 clear empties line 0
        wr(12'h008, 2'd2, 32'h0000_0080, 0, "R6 clear last bit");
        rd(12'h008, 2'd2, "R6 status zero");
        // R6 removing enable drops line 1, restoring raises it
        wr(12'h01C, 2'd2, 32'h0, 0, "R6 disable line1");
        wr(12'h01C, 2'd2, 32'hFF00_0000, 0, "R6 enable line1");
        // R10 half-word
        wr(12'h026, 2'd1, 32'hAAAA_1234, 0, "R10 upper half write");
        rd(12'h026, 2'd1, "R10 upper half read");
        rd(12'h024, 2'd1, "R10 lower half read");
        rd(12'h024, 2'd2, "R10 word read");
        // R8 byte and reserved
        wr(12'h020, 2'd0, 32'hFF, 0, "R8 byte write");
        wr(12'h020, 2'd3, 32'hFF, 0, "R8 reserved write");
        rd(12'h020, 2'd2, "R8 enable unchanged");
        rd(12'h000, 2'd0, "R8 byte read");
        rd(12'h080, 2'd0, "R8 byte channel read");
        // R7 channel decode
        rd(12'h080, 2'd2, "R7 ch0 off0");
        wr(12'h0E0, 2'd2, 32'h5, 0, "R7 ch1 write");
        rd(12'h0DE, 2'd1, "R7 ch0 last half");
        rd(12'hC7C, 2'd2, "R7 last channel end");
        // R9 unmapped
        rd(12'hC80, 2'd2, "R9 channel beyond count");
        rd(12'hFFC, 2'd2, "R9 window top");
        rd(12'h004, 2'd2, "R9 gap 0x04");
        rd(12'h028, 2'd2, "R9 gap 0x28");
        rd(12'h07C, 2'd2, "R9 gap 0x7C");

        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            logic [31:0] d;
            logic [31:0] ev;
            case ($urandom_range(0, 3))
                0: a = 12'(8 + 4 * $urandom_range(0, 3)) | 12'(2 * $urandom_range(0, 1));
                1: a = 12'(24 + 4 * $urandom_range(0, 3)) | 12'(2 * $urandom_range(0, 1));
                2: a = 12'($urandom_range(0, 4095));
                default: a = 12'($urandom_range(0, 63));
            endcase
            d  = $urandom;
            ev = $urandom & $urandom & $urandom;
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a,
                 2'($urandom_range(0, 3)), d, ev, "R3 R4 R5 R10 random");
        end
        step(1'b0, 1'b0, 0, 2'd2, 0, 0, "idle");
        step(1'b0, 1'b0, 0, 2'd2, 0, 0, "idle");
        report();
        $finish;
    end

endmodule